// File: doc/BRIEF.md
# Video Memory Masked and Block Write Path

This block is the write side of a video frame memory column slice. A strobe decoder outside it reports when a row opens and closes and when a column strobe arrives. Two flags are sampled as the row opens: a bit-select flag and a special-function flag. Together they choose how every column write in that row behaves. There are three write behaviours: all four bits written, bits gated by a mask captured at row open, and bits gated by a mask held in a register. A fourth row kind does not write the array at all. Its column strobes load the on-chip color register or the held mask register instead.

Within a write row, a column strobe with the column special-function flag low writes the data bus to one column. With that flag high, it performs a block fill. The two low column address bits are dropped. Each data bus bit then selects one of the four aligned columns, and every selected column receives the color register value. The active bit mask still gates every write. The block drives a four-lane write-enable vector, an aligned base column, a bit-enable nibble and write data into a behavioral array, and that array has a combinational read port.

The row-mode state machine has five states. ST_IDLE has no row open. ST_PLAIN writes every bit. ST_MASK_CYC uses the mask captured at row open. ST_MASK_HELD uses the stored mask register. ST_LOAD_REG loads registers only. Its transitions are: open_plain (ST_IDLE to ST_PLAIN), open_cyc (ST_IDLE to ST_MASK_CYC), open_held (ST_IDLE to ST_MASK_HELD), open_load (ST_IDLE to ST_LOAD_REG), and close (any open state back to ST_IDLE).

Top module: `vram_write_path`

## Requirements
- R1: After reset the color register, the held mask register and every array column hold 0, the row-mode state is ST_IDLE, and `wr_lane_en` is 0.
- R2: A `row_open` pulse in ST_IDLE selects the row mode. `{bitsel_row,sf_row}` = 00 selects ST_PLAIN, 10 selects ST_MASK_CYC (capturing `dbus` as the cycle mask), 11 selects ST_MASK_HELD, and 01 selects ST_LOAD_REG. A `row_open` while a row is already open is ignored, and `row_close` returns to ST_IDLE.
- R3: In ST_PLAIN, a column strobe with `wr_req`=1 and `sf_col`=0 writes all four bits of `dbus` into column `col_addr` and leaves every other column unchanged.
- R4: In ST_MASK_CYC, bit i of a normal or block write is written only when bit i of the mask captured at row open is 1. Bits whose mask bit is 0 keep their stored value.
- R5: In ST_MASK_HELD, the held mask register gates the bits in the same way as R4.
- R6: In ST_LOAD_REG, a column strobe with `wr_req`=1 loads `dbus` into the color register when `sf_col`=1, or into the held mask register when `sf_col`=0. The array is not written.
- R7: A block write (`sf_col`=1 in a write row) ignores `col_addr[1:0]`. It writes the color register into column base+i for every i where `dbus[i]`=1, with base = `col_addr` with its two low bits cleared, and the bit mask still applies. Columns with `dbus[i]`=0 are unchanged.
- R8: A column strobe with `wr_req`=0, or any column strobe in ST_IDLE, changes no array column or register, and `wr_lane_en` stays 0.
- R9: The write outputs change in the cycle after the accepted column strobe. For a normal write, lane `col_addr[1:0]` alone is set in `wr_lane_en`. For a block write, `wr_lane_en` equals `dbus`. Otherwise it is 0. The array column reads back the new value one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_open | input | 1 | Row-open pulse from the strobe decoder |
| row_close | input | 1 | Row-close pulse |
| bitsel_row | input | 1 | Bit-select flag sampled at row open |
| sf_row | input | 1 | Special-function flag sampled at row open |
| col_go | input | 1 | Column strobe pulse |
| wr_req | input | 1 | Write strobe qualifying the column strobe |
| sf_col | input | 1 | Special-function flag at the column strobe (block fill or color load) |
| col_addr | input | $clog2(COLS) | Column address |
| dbus | input | 4 | Data, mask or column-select bits |
| rd_col | input | $clog2(COLS) | Array read column |
| rd_data | output | 4 | Array read data |
| wr_lane_en | output | 4 | Per-column write enables for the four aligned columns |
| wr_base | output | $clog2(COLS) | Aligned base column of the write |
| wr_bit_en | output | 4 | Per-bit write enables |
| wr_data | output | 4 | Write data |

## Verification
Every cycle, the assertions check the following properties of the write outputs. The outputs stay quiet without a column strobe and in register-load rows. A normal write never enables more than one lane. A block fill enables only lanes named on the data bus and carries the color value. The bit enables equal all-ones in plain rows and the held mask in held-mask rows. Whether masked bits really keep their old contents, whether lane enables land on the right aligned columns, and whether mode choice and register loads take effect can only be seen from the bench scenarios. The bench reads the array back and compares it against a reference model across random and directed row sequences.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
    localparam int LANES = 4;
    localparam int SUB_W = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAIN,
        ST_MASK_CYC,
        ST_MASK_HELD,
        ST_LOAD_REG
    } vwr_state_e;
endpackage

// File: rtl/vwr_mode_fsm.sv
module vwr_mode_fsm
    import vwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_open,
    input  logic             row_close,
    input  logic             bitsel_row,
    input  logic             sf_row,
    input  logic [LANES-1:0] dbus,
    output vwr_state_e       mode_o,
    output logic [LANES-1:0] cyc_mask_o
);
    vwr_state_e       state_q, state_d;
    logic [LANES-1:0] cyc_mask_q, cyc_mask_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cyc_mask_q <= '0;
        end else begin
            state_q    <= state_d;
            cyc_mask_q <= cyc_mask_d;
        end
    end

    // next state and captured mask
    always_comb begin
        state_d    = state_q;
        cyc_mask_d = cyc_mask_q;
        unique case (state_q)
            ST_IDLE: begin
                if (row_open && !row_close) begin
                    unique case ({bitsel_row, sf_row})
                        2'b00: state_d = ST_PLAIN;
                        2'b10: begin
                            state_d    = ST_MASK_CYC;
                            cyc_mask_d = dbus;
                        end
                        2'b11: state_d = ST_MASK_HELD;
                        2'b01: state_d = ST_LOAD_REG;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PLAIN, ST_MASK_CYC, ST_MASK_HELD, ST_LOAD_REG: begin
                if (row_close) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mode_o     = state_q;
    assign cyc_mask_o = cyc_mask_q;
endmodule

// File: rtl/vwr_regs.sv
module vwr_regs
    import vwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             sel_color,
    input  logic [LANES-1:0] dbus,
    output logic [LANES-1:0] color_o,
    output logic [LANES-1:0] held_mask_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color_o     <= '0;
            held_mask_o <= '0;
        end else if (load_en) begin
            if (sel_color) color_o     <= dbus;
            else           held_mask_o <= dbus;
        end
    end
endmodule

// File: rtl/vwr_lane_gen.sv
module vwr_lane_gen
    import vwr_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vwr_state_e       mode,
    input  logic             col_go,
    input  logic             wr_req,
    input  logic             sf_col,
    input  logic [COL_W-1:0] col_addr,
    input  logic [LANES-1:0] dbus,
    input  logic [LANES-1:0] color,
    input  logic [LANES-1:0] cyc_mask,
    input  logic [LANES-1:0] held_mask,
    output logic             reg_load,
    output logic             reg_sel_color,
    output logic [LANES-1:0] lane_en_q,
    output logic [COL_W-1:0] base_q,
    output logic [LANES-1:0] bit_en_q,
    output logic [LANES-1:0] data_q
);
    logic             write_row, accept;
    logic [LANES-1:0] eff_mask, onehot, lane_d, data_d;
    logic [COL_W-1:0] base_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign onehot[l] = (col_addr[SUB_W-1:0] == SUB_W'(l));
    end

    always_comb begin
        write_row = 1'b0;
        eff_mask  = '0;
        unique case (mode)
            ST_PLAIN: begin
                write_row = 1'b1;
                eff_mask  = '1;
            end
            ST_MASK_CYC: begin
                write_row = 1'b1;
                eff_mask  = cyc_mask;
            end
            ST_MASK_HELD: begin
                write_row = 1'b1;
                eff_mask  = held_mask;
            end
            ST_IDLE, ST_LOAD_REG: begin
                write_row = 1'b0;
                eff_mask  = '0;
            end
            default: begin
                write_row = 1'b0;
                eff_mask  = '0;
            end
        endcase
    end

    assign accept        = col_go && wr_req && write_row;
    assign reg_load      = col_go && wr_req && (mode == ST_LOAD_REG);
    assign reg_sel_color = sf_col;
    assign lane_d        = !accept ? '0 : (sf_col ? dbus : onehot);
    assign data_d        = sf_col ? color : dbus;
    assign base_d        = {col_addr[COL_W-1:SUB_W], {SUB_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_en_q <= '0;
            base_q    <= '0;
            bit_en_q  <= '0;
            data_q    <= '0;
        end else begin
            lane_en_q <= lane_d;
            base_q    <= accept ? base_d : '0;
            bit_en_q  <= accept ? eff_mask : '0;
            data_q    <= accept ? data_d : '0;
        end
    end
endmodule

// File: rtl/vwr_array.sv
module vwr_array
    import vwr_pkg::*;
#(
    parameter int COLS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_en,
    input  logic [$clog2(COLS)-1:0] base,
    input  logic [LANES-1:0]        bit_en,
    input  logic [LANES-1:0]        data,
    input  logic [$clog2(COLS)-1:0] rd_col,
    output logic [LANES-1:0]        rd_data
);
    localparam int COL_W = $clog2(COLS);

    logic [LANES-1:0] cells [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam logic [COL_W-1:0] CBASE = COL_W'(c - (c % LANES));
        localparam int               LANE  = c % LANES;
        logic [LANES-1:0] cell_q;
        logic             hit;

        assign hit = lane_en[LANE] && (base == CBASE);

        always_ff @(posedge clk) begin
            if (!rst_n)   cell_q <= '0;
            else if (hit) cell_q <= (cell_q & ~bit_en) | (data & bit_en);
        end

        assign cells[c] = cell_q;
    end

    assign rd_data = cells[rd_col];
endmodule

// File: rtl/vram_write_path.sv
module vram_write_path
    import vwr_pkg::*;
#(
    parameter int COLS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    row_open,
    input  logic                    row_close,
    input  logic                    bitsel_row,
    input  logic                    sf_row,
    input  logic                    col_go,
    input  logic                    wr_req,
    input  logic                    sf_col,
    input  logic [$clog2(COLS)-1:0] col_addr,
    input  logic [3:0]              dbus,
    input  logic [$clog2(COLS)-1:0] rd_col,
    output logic [3:0]              rd_data,
    output logic [3:0]              wr_lane_en,
    output logic [$clog2(COLS)-1:0] wr_base,
    output logic [3:0]              wr_bit_en,
    output logic [3:0]              wr_data
);
    localparam int COL_W = $clog2(COLS);

    vwr_state_e       mode_q;
    logic [LANES-1:0] cyc_mask_q, color_q, held_mask_q;
    logic             reg_load, reg_sel_color;

    vwr_mode_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_open   (row_open),
        .row_close  (row_close),
        .bitsel_row (bitsel_row),
        .sf_row     (sf_row),
        .dbus       (dbus),
        .mode_o     (mode_q),
        .cyc_mask_o (cyc_mask_q)
    );

    vwr_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (reg_load),
        .sel_color   (reg_sel_color),
        .dbus        (dbus),
        .color_o     (color_q),
        .held_mask_o (held_mask_q)
    );

    vwr_lane_gen #(.COL_W(COL_W)) lane_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode_q),
        .col_go        (col_go),
        .wr_req        (wr_req),
        .sf_col        (sf_col),
        .col_addr      (col_addr),
        .dbus          (dbus),
        .color         (color_q),
        .cyc_mask      (cyc_mask_q),
        .held_mask     (held_mask_q),
        .reg_load      (reg_load),
        .reg_sel_color (reg_sel_color),
        .lane_en_q     (wr_lane_en),
        .base_q        (wr_base),
        .bit_en_q      (wr_bit_en),
        .data_q        (wr_data)
    );

    vwr_array #(.COLS(COLS)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_en (wr_lane_en),
        .base    (wr_base),
        .bit_en  (wr_bit_en),
        .data    (wr_data),
        .rd_col  (rd_col),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/vwr_write_chk.sv
module vwr_write_chk
    import vwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       col_go,
    input logic       wr_req,
    input logic       sf_col,
    input logic [3:0] dbus,
    input logic [3:0] wr_lane_en,
    input logic [3:0] wr_bit_en,
    input logic [3:0] wr_data,
    input vwr_state_e mode_q,
    input logic [3:0] color_q,
    input logic [3:0] held_mask_q
);
    logic write_row;
    assign write_row = (mode_q == ST_PLAIN) || (mode_q == ST_MASK_CYC) ||
                       (mode_q == ST_MASK_HELD);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (wr_lane_en == 4'b0));

    // R8
    no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !col_go |=> (wr_lane_en == 4'b0));

    // R6
    load_row_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go && mode_q == ST_LOAD_REG) |=> (wr_lane_en == 4'b0));

    // R7
    block_lane_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go && wr_req && sf_col) |=> ((wr_lane_en & ~$past(dbus)) == 4'b0));

    // R7
    block_color_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go && wr_req && sf_col && write_row) |=> (wr_data == $past(color_q)));

    // R3
    single_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go && !sf_col) |=> ($countones(wr_lane_en) <= 1));

    // R3
    plain_all_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go && wr_req && mode_q == ST_PLAIN) |=> (wr_bit_en == 4'hF));

    // R5
    held_mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_go && wr_req && mode_q == ST_MASK_HELD) |=> (wr_bit_en == $past(held_mask_q)));
endmodule

bind vram_write_path vwr_write_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_go      (col_go),
    .wr_req      (wr_req),
    .sf_col      (sf_col),
    .dbus        (dbus),
    .wr_lane_en  (wr_lane_en),
    .wr_bit_en   (wr_bit_en),
    .wr_data     (wr_data),
    .mode_q      (mode_q),
    .color_q     (color_q),
    .held_mask_q (held_mask_q)
);

// File: tb/vram_write_path_tb_top.sv
`timescale 1ns/1ps
module vram_write_path_tb_top;
    localparam int COLS  = 64;
    localparam int COL_W = $clog2(COLS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             row_open = 0, row_close = 0, bitsel_row = 0, sf_row = 0;
    logic             col_go = 0, wr_req = 0, sf_col = 0;
    logic [COL_W-1:0] col_addr = '0, rd_col = '0;
    logic [3:0]       dbus = '0;
    logic [3:0]       rd_data, wr_lane_en, wr_bit_en, wr_data;
    logic [COL_W-1:0] wr_base;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model: 0 idle, 1 plain, 2 cycle mask, 3 held mask, 4 load
    int         m_state = 0;
    logic [3:0] m_cyc = 0, m_held = 0, m_color = 0;
    logic [3:0] m_mem [COLS];

    always #2 clk = ~clk;

    vram_write_path #(.COLS(COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .row_open(row_open), .row_close(row_close),
        .bitsel_row(bitsel_row), .sf_row(sf_row), .col_go(col_go), .wr_req(wr_req),
        .sf_col(sf_col), .col_addr(col_addr), .dbus(dbus), .rd_col(rd_col),
        .rd_data(rd_data), .wr_lane_en(wr_lane_en), .wr_base(wr_base),
        .wr_bit_en(wr_bit_en), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] mask_of(input int st);
        case (st)
            1: return 4'hF;
            2: return m_cyc;
            3: return m_held;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [3:0] exp_lanes(input bit wr, input bit sf, input int col,
                                             input logic [3:0] d);
        if (!wr || m_state < 1 || m_state > 3) return 4'h0;
        if (sf) return d;
        return 4'(1 << (col % 4));
    endfunction

    task automatic open_row(input bit bs, input bit sf, input logic [3:0] d);
        @(negedge clk);
        row_open = 1; bitsel_row = bs; sf_row = sf; dbus = d;
        @(negedge clk);
        row_open = 0; bitsel_row = 0; sf_row = 0; dbus = 0;
        if (m_state == 0) begin
            case ({bs, sf})
                2'b00: m_state = 1;
                2'b10: begin m_state = 2; m_cyc = d; end
                2'b11: m_state = 3;
                default: m_state = 4;
            endcase
        end
    endtask

    task automatic close_row();
        @(negedge clk);
        row_close = 1;
        @(negedge clk);
        row_close = 0;
        m_state = 0;
    endtask

    task automatic col_op(input bit wr, input bit sf, input int col, input logic [3:0] d);
        logic [3:0] lanes, mk, val;
        int base;
        @(negedge clk);
        col_go = 1; wr_req = wr; sf_col = sf; col_addr = COL_W'(col); dbus = d;
        lanes = exp_lanes(wr, sf, col, d);
        @(negedge clk);
        // R9: write outputs appear one cycle after the strobe
        check("R9 lanes", {4'h0, wr_lane_en}, {4'h0, lanes});
        col_go = 0; wr_req = 0; sf_col = 0; dbus = 0;
        mk   = mask_of(m_state);
        base = col - (col % 4);
        val  = sf ? m_color : d;
        for (int i = 0; i < 4; i++)
            if (lanes[i]) m_mem[base + i] = (m_mem[base + i] & ~mk) | (val & mk);
        if (wr && m_state == 4) begin
            if (sf) m_color = d;
            else    m_held  = d;
        end
    endtask

    task automatic read_col(input int c, output logic [3:0] v);
        @(negedge clk);
        rd_col = COL_W'(c);
        #1;
        v = rd_data;
    endtask

    task automatic check_col(input string req, input int c, input logic [3:0] exp);
        logic [3:0] v;
        read_col(c, v);
        check(req, {4'h0, v}, {4'h0, exp});
    endtask

    task automatic compare_all(input string req);
        for (int c = 0; c < COLS; c++) check_col(req, c, m_mem[c]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int c = 0; c < COLS; c++) m_mem[c] = 4'h0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 lanes in reset", {4'h0, wr_lane_en}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        check("R1 lanes after reset", {4'h0, wr_lane_en}, 8'h00);
        compare_all("R1 array clear");

        // R3: plain write
        open_row(0, 0, 4'h0);
        col_op(1, 0, 5, 4'hA);
        close_row();
        check_col("R3 plain write", 5, 4'hA);
        check_col("R3 neighbour untouched", 4, 4'h0);

        // R4: cycle mask 0011
        open_row(1, 0, 4'h3);
        col_op(1, 0, 5, 4'h5);
        close_row();
        check_col("R4 cycle mask", 5, 4'h9);

        // R6: register loads, array untouched
        open_row(0, 1, 4'h0);
        col_op(1, 0, 5, 4'h6);
        col_op(1, 1, 5, 4'hF);
        close_row();
        check_col("R6 load leaves array", 5, 4'h9);

        // R5: held mask 0110
        open_row(1, 1, 4'h0);
        col_op(1, 0, 5, 4'hF);
        col_op(1, 0, 6, 4'hF);
        close_row();
        check_col("R5 held mask col5", 5, 4'hF);
        check_col("R5 held mask col6", 6, 4'h6);

        // R7: block fill in plain row, low address bits ignored
        open_row(0, 0, 4'h0);
        col_op(1, 1, 10, 4'b1011);
        close_row();
        check_col("R7 block col8", 8, 4'hF);
        check_col("R7 block col9", 9, 4'hF);
        check_col("R7 block col10 skipped", 10, 4'h0);
        check_col("R7 block col11", 11, 4'hF);

        // R7 with held mask applied
        open_row(1, 1, 4'h0);
        col_op(1, 1, 13, 4'hF);
        close_row();
        for (int c = 12; c < 16; c++) check_col("R7 block masked", c, 4'h6);

        // R8: no write strobe, and strobe while idle
        open_row(0, 0, 4'h0);
        col_op(0, 0, 20, 4'hC);
        close_row();
        col_op(1, 0, 21, 4'hC);
        col_op(1, 1, 22, 4'hF);
        check_col("R8 no wr_req", 20, 4'h0);
        check_col("R8 idle strobe", 21, 4'h0);
        check_col("R8 idle block", 23, 4'h0);

        // R2: row_open while open is ignored (stays plain)
        open_row(0, 0, 4'h0);
        open_row(1, 0, 4'h0);
        col_op(1, 0, 24, 4'h7);
        close_row();
        check_col("R2 reopen ignored", 24, 4'h7);

        // random mix
        for (int r = 0; r < 200; r++) begin
            int md, nops;
            md = $urandom % 4;
            open_row(md[1], md[0], 4'($urandom));
            nops = 1 + $urandom % 4;
            for (int k = 0; k < nops; k++)
                col_op(($urandom % 8) != 0, ($urandom % 3) == 0,
                       $urandom % COLS, 4'($urandom));
            close_row();
            if (r % 40 == 39) compare_all("R2 R3 R4 R5 R6 R7 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule